// File: doc/BRIEF.md
# Request/Acknowledge Framed SPI Slave Sequencer

This block hands a two-byte command code and a run of payload bytes to an external host controller over SPI. The bridge is the SPI slave. The host owns the serial clock. A two-wire handshake gates the bus. The bridge raises a request line. The host answers on an acknowledge line once it has released its own use of the shared serial bus. The bridge then enables its serial output and withdraws the request. The host clocks out the bytes it is owed and closes the phase by dropping acknowledge.

A frame has one command phase of exactly two bytes. When the payload length is not zero, a payload phase follows, carrying the bytes read from an internal buffer. The buffer is addressed by byte index through a combinational read port. Serial transfer uses a clock that idles low. The host samples on the rising edge and the slave changes data on the falling edge. Each byte goes most significant bit first.

The sequencer ends every frame with a single completion pulse and an outcome code. It catches three faults: a payload request that is too long, a host that never answers the request, and a host that ends a phase before all of its bits have been clocked.

Top module: `spi_req_ack_handoff`

## Requirements
- R1: After reset, reqOut, misoOe, misoOut, busy and done are 0, and errCode is 0.
- R2: A start pulse while idle, with dataLen at most MAX_BYTES, raises busy and reqOut on the next cycle. reqOut stays high until the synchronised ackIn is seen high.
- R3: Once ackIn is seen high during a request, reqOut falls and misoOe rises. misoOe and reqOut are never high together. A host that samples misoOut on each rising sclkIn edge receives opCode[15:8] and then opCode[7:0], MSB first.
- R4: When the command phase ends with at least 16 bits clocked and dataLen > 0, reqOut rises again. After the next acknowledge, the host receives buffer bytes 0 to dataLen-1 in order, MSB first. Byte i is read through bufAddr = i.
- R5: With dataLen = 0, the frame completes with errCode 0 when the command phase closes, and reqOut does not rise again.
- R6: done is a one-cycle pulse at the end of every frame. errCode changes only together with done and holds until the next completion. Codes: 0 success, 1 length rejected, 2 acknowledge timeout, 3 short phase.
- R7: A start with dataLen > MAX_BYTES never raises reqOut. The next cycle shows done with errCode 1.
- R8: If no acknowledge arrives, reqOut stays high for exactly TIMEOUT_CYC cycles. It then falls in the same cycle that done rises with errCode 2. This applies in both phases.
- R9: If ackIn falls before all bits of a phase are clocked (16 for the command phase, 8*dataLen for the payload phase), the frame ends with done and errCode 3, and reqOut stays low.
- R10: misoOe is high only while a phase is shifting. misoOut is 0 whenever misoOe is low. Bits clocked beyond the end of a phase read as 0.
- R11: A start pulse while busy has no effect on the frame in progress, including its bytes and its outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame (accepted only when idle) |
| opCode | input | 16 | Two-byte command code, high byte sent first |
| dataLen | input | LEN_W | Payload byte count |
| bufAddr | output | ADDR_W | Payload buffer read index |
| bufData | input | 8 | Payload buffer read data (combinational) |
| reqOut | output | 1 | Request to host |
| ackIn | input | 1 | Acknowledge from host (asynchronous) |
| sclkIn | input | 1 | SPI clock from host (asynchronous, idle low) |
| misoOut | output | 1 | Serial data to host |
| misoOe | output | 1 | Output enable for misoOut pad |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle frame completion pulse |
| errCode | output | 2 | Outcome of the last completed frame |

## Verification
Most internal faults in this block show up directly in the serial bytes. A bit counter that is off by one, or a misplaced byte reload, shifts or repeats bits in the stream the host samples, and this is visible on the first byte boundary after the fault. A wrong state transition shows as a request line that rises when it should not, stays high too long, or fails to rise again for the payload phase. A wrong short-phase or timeout decision shows in the errCode that arrives with done, two to three cycles after the acknowledge falls or exactly TIMEOUT_CYC cycles after the request rises. The bench sweeps small and boundary payload lengths and derives every byte arithmetically from the index.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic capture;    // latch opcode and length
    logic loadFirst;  // clear bit count, load byte 0 of the phase
    logic shiftEn;    // phase active: follow sclk, drive miso
    logic dataPhase;  // select payload source instead of opcode
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ_OP, ST_OP_SHIFT, ST_REQ_DATA, ST_DATA_SHIFT
  } hskState_t;

  localparam logic [1:0] ERR_NONE     = 2'd0;
  localparam logic [1:0] ERR_TOO_LONG = 2'd1;
  localparam logic [1:0] ERR_TIMEOUT  = 2'd2;
  localparam logic [1:0] ERR_SHORT    = 2'd3;

endpackage

// File: rtl/hsk_dpath.sv
module hsk_dpath
  import hsk_pkg::*;
#(
  parameter int MAX_BYTES = 64,
  parameter int LEN_W     = 8,
  parameter int CNT_W     = 10,
  parameter int ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [15:0]       opCode,
  input  logic [LEN_W-1:0]  dataLen,
  input  logic              sclkIn,
  input  logic [7:0]        bufData,
  output logic [ADDR_W-1:0] bufAddr,
  output logic [LEN_W-1:0]  lenQ,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              miso
);

  localparam int IDX_W = CNT_W - 3;

  logic [2:0]       sclkSync;
  logic             sclkRise, sclkFall;
  logic [15:0]      opQ;
  logic [7:0]       shReg;
  logic [IDX_W-1:0] byteIdx;
  logic [7:0]       nextByte;
  logic [CNT_W-1:0] idxWide, lenWide;

  assign sclkRise = sclkSync[1] & ~sclkSync[2];
  assign sclkFall = ~sclkSync[1] & sclkSync[2];

  // Byte index of the next byte to load
  assign byteIdx = stb.loadFirst ? '0 : bitCnt[CNT_W-1:3];
  assign bufAddr = byteIdx[ADDR_W-1:0];
  assign idxWide = CNT_W'(byteIdx);
  assign lenWide = CNT_W'(lenQ);

  always_comb begin
    nextByte = 8'h00;
    if (stb.dataPhase) begin
      if (idxWide < lenWide) nextByte = bufData;
    end else if (byteIdx == IDX_W'(0)) begin
      nextByte = opQ[15:8];
    end else if (byteIdx == IDX_W'(1)) begin
      nextByte = opQ[7:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      opQ      <= '0;
      lenQ     <= '0;
      shReg    <= '0;
      bitCnt   <= '0;
    end else begin
      sclkSync <= {sclkSync[1:0], sclkIn};
      if (stb.capture) begin
        opQ  <= opCode;
        lenQ <= dataLen;
      end
      if (stb.loadFirst) begin
        bitCnt <= '0;
        shReg  <= nextByte;
      end else if (stb.shiftEn) begin
        if (sclkRise && bitCnt != '1) bitCnt <= bitCnt + 1'b1;
        if (sclkFall) begin
          if (bitCnt[2:0] == 3'd0 && bitCnt != '0) shReg <= nextByte;
          else shReg <= {shReg[6:0], 1'b0};
        end
      end
    end
  end

  assign miso = stb.shiftEn ? shReg[7] : 1'b0;

  // A rising sclk during a phase advances the count by exactly one
  AST_RISE_COUNTS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.shiftEn && !stb.loadFirst && sclkRise && bitCnt < CNT_W'(MAX_BYTES*8))
      |=> (bitCnt == $past(bitCnt) + 1'b1)); // R4

endmodule

// File: rtl/hsk_ctrl.sv
module hsk_ctrl
  import hsk_pkg::*;
#(
  parameter int MAX_BYTES   = 64,
  parameter int TIMEOUT_CYC = 4096,
  parameter int LEN_W       = 8,
  parameter int CNT_W       = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] dataLen,
  input  logic [LEN_W-1:0] lenQ,
  input  logic [CNT_W-1:0] bitCnt,
  input  logic             ackIn,
  output dpStrobe_t        stb,
  output logic             reqOut,
  output logic             busy,
  output logic             done,
  output logic [1:0]       errCode
);

  localparam int TO_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] OP_BITS = CNT_W'(16);

  hskState_t        state;
  logic [TO_W-1:0]  waitCnt;
  logic [2:0]       ackSync;
  logic             ackS, ackFall, tooLong;
  logic [CNT_W-1:0] dataBits;

  assign ackS     = ackSync[1];
  assign ackFall  = ackSync[2] & ~ackSync[1];
  assign tooLong  = dataLen > LEN_W'(MAX_BYTES);
  assign dataBits = CNT_W'(lenQ) << 3;

  always_comb begin
    stb.capture   = (state == ST_IDLE) && start;
    stb.loadFirst = (state == ST_REQ_OP || state == ST_REQ_DATA) && ackS;
    stb.shiftEn   = (state == ST_OP_SHIFT || state == ST_DATA_SHIFT);
    stb.dataPhase = (state == ST_REQ_DATA || state == ST_DATA_SHIFT);
  end

  assign reqOut = (state == ST_REQ_OP || state == ST_REQ_DATA);
  assign busy   = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      ackSync <= '0;
      done    <= 1'b0;
      errCode <= ERR_NONE;
    end else begin
      ackSync <= {ackSync[1:0], ackIn};
      done    <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          if (tooLong) begin
            done    <= 1'b1;
            errCode <= ERR_TOO_LONG;
          end else begin
            state   <= ST_REQ_OP;
            waitCnt <= '0;
          end
        end
        ST_REQ_OP, ST_REQ_DATA: begin
          if (ackS) begin
            state <= (state == ST_REQ_OP) ? ST_OP_SHIFT : ST_DATA_SHIFT;
          end else if (waitCnt == TO_W'(TIMEOUT_CYC - 1)) begin
            state   <= ST_IDLE;
            done    <= 1'b1;
            errCode <= ERR_TIMEOUT;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_OP_SHIFT: if (ackFall) begin
          if (bitCnt < OP_BITS) begin
            state   <= ST_IDLE;
            done    <= 1'b1;
            errCode <= ERR_SHORT;
          end else if (lenQ == '0) begin
            state   <= ST_IDLE;
            done    <= 1'b1;
            errCode <= ERR_NONE;
          end else begin
            state   <= ST_REQ_DATA;
            waitCnt <= '0;
          end
        end
        ST_DATA_SHIFT: if (ackFall) begin
          state   <= ST_IDLE;
          done    <= 1'b1;
          errCode <= (bitCnt < dataBits) ? ERR_SHORT : ERR_NONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    reqOut |-> (waitCnt < TO_W'(TIMEOUT_CYC))); // R8

  AST_SHORT_OPCODE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OP_SHIFT && ackFall && bitCnt < OP_BITS)
      |=> (done && errCode == ERR_SHORT && !reqOut)); // R9

endmodule

// File: rtl/spi_req_ack_handoff.sv
module spi_req_ack_handoff
  import hsk_pkg::*;
#(
  parameter int MAX_BYTES   = 64,
  parameter int TIMEOUT_CYC = 4096,
  parameter int LEN_W       = 8,
  localparam int CNT_W      = $clog2(MAX_BYTES * 8 + 1),
  localparam int ADDR_W     = $clog2(MAX_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [15:0]       opCode,
  input  logic [LEN_W-1:0]  dataLen,
  output logic [ADDR_W-1:0] bufAddr,
  input  logic [7:0]        bufData,
  output logic              reqOut,
  input  logic              ackIn,
  input  logic              sclkIn,
  output logic              misoOut,
  output logic              misoOe,
  output logic              busy,
  output logic              done,
  output logic [1:0]        errCode
);

  dpStrobe_t        stb;
  logic [LEN_W-1:0] lenQ;
  logic [CNT_W-1:0] bitCnt;

  hsk_ctrl #(
    .MAX_BYTES(MAX_BYTES), .TIMEOUT_CYC(TIMEOUT_CYC),
    .LEN_W(LEN_W), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .dataLen(dataLen),
    .lenQ(lenQ), .bitCnt(bitCnt), .ackIn(ackIn), .stb(stb),
    .reqOut(reqOut), .busy(busy), .done(done), .errCode(errCode)
  );

  hsk_dpath #(
    .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .opCode(opCode), .dataLen(dataLen),
    .sclkIn(sclkIn), .bufData(bufData), .bufAddr(bufAddr), .lenQ(lenQ),
    .bitCnt(bitCnt), .miso(misoOut)
  );

  assign misoOe = stb.shiftEn;

  AST_REQ_OE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(reqOut && misoOe)); // R3

  AST_OE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    misoOe |-> busy); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(errCode) |-> done); // R6

  AST_REJECT_LONG: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && dataLen > LEN_W'(MAX_BYTES))
      |=> (done && errCode == ERR_TOO_LONG && !reqOut)); // R7

endmodule

// File: tb/spi_req_ack_handoff_tb_top.sv
module spi_req_ack_handoff_tb_top;

  localparam int MAXB = 64;
  localparam int TO   = 20;
  localparam int HALF = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] opCode = '0;
  logic [7:0]  dataLen = '0;
  logic [5:0]  bufAddr;
  logic [7:0]  bufData;
  logic        reqOut, misoOut, misoOe, busy, done;
  logic [1:0]  errCode;
  logic        ackIn = 1'b0;
  logic        sclkIn = 1'b0;

  int nChk = 0;
  int nFail = 0;
  int curSeed = 0;
  logic [7:0] rx [0:79];

  always #4 clk = ~clk;

  function automatic logic [7:0] memVal(input int idx, input int seed);
    return 8'((idx * 37 + seed * 11 + 5) ^ (idx >> 1));
  endfunction

  assign bufData = memVal(int'(bufAddr), curSeed);

  spi_req_ack_handoff #(.MAX_BYTES(MAXB), .TIMEOUT_CYC(TO), .LEN_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .opCode(opCode), .dataLen(dataLen),
    .bufAddr(bufAddr), .bufData(bufData), .reqOut(reqOut), .ackIn(ackIn),
    .sclkIn(sclkIn), .misoOut(misoOut), .misoOe(misoOe), .busy(busy),
    .done(done), .errCode(errCode)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shiftBits(input int nBits);
    for (int i = 0; i < nBits; i++) begin
      rx[i/8] = {rx[i/8][6:0], misoOut};
      sclkIn = 1'b1;
      tick(HALF);
      sclkIn = 1'b0;
      tick(HALF);
    end
  endtask

  task automatic waitReq(output bit seen);
    seen = 0;
    for (int i = 0; i < 60 && !seen; i++) begin
      if (reqOut) seen = 1;
      else tick(1);
    end
  endtask

  task automatic waitDone(output bit seen, output bit reqSeen);
    seen = 0;
    reqSeen = 0;
    for (int i = 0; i < 60 && !seen; i++) begin
      if (reqOut) reqSeen = 1;
      if (done) seen = 1;
      else tick(1);
    end
  endtask

  task automatic pulseStart(input logic [15:0] op, input int len);
    opCode = op;
    dataLen = 8'(len);
    start = 1'b1;
    tick(1);
    start = 1'b0;
  endtask

  // Full frame; extra = additional bits clocked past the payload; poke = start while busy
  task automatic runFrame(input logic [15:0] op, input int len, input int extra,
                          input int seed, input bit poke);
    bit seen, rs;
    curSeed = seed;
    pulseStart(op, len);
    waitReq(seen);
    check(seen && busy, "R2 request after start", int'(reqOut), 1);
    ackIn = 1'b1;
    tick(8);
    check(!reqOut && misoOe, "R3 request drops and output enabled", int'({reqOut, misoOe}), 1);
    if (poke) begin
      opCode = 16'hFFFF; dataLen = 8'd100; start = 1'b1;
      tick(1);
      start = 1'b0;
    end
    shiftBits(16);
    tick(4);
    ackIn = 1'b0;
    check(rx[0] == op[15:8], "R3 opcode high byte", int'(rx[0]), int'(op[15:8]));
    check(rx[1] == op[7:0], "R3 opcode low byte", int'(rx[1]), int'(op[7:0]));
    if (poke) check(busy, "R11 start while busy ignored", int'(busy), 1);
    if (len > 0) begin
      waitReq(seen);
      check(seen, "R4 second request", int'(seen), 1);
      ackIn = 1'b1;
      tick(8);
      shiftBits(len * 8 + extra);
      tick(4);
      ackIn = 1'b0;
      for (int i = 0; i < len; i++)
        check(rx[i] == memVal(i, seed), "R4 payload byte", int'(rx[i]), int'(memVal(i, seed)));
      if (extra > 0)
        check(rx[len] == 8'h00, "R10 bits past payload read 0", int'(rx[len]), 0);
    end
    waitDone(seen, rs);
    check(seen && errCode == 2'd0, "R6 done with success code", int'(errCode), 0);
    if (len == 0) check(!rs, "R5 no second request for empty payload", int'(rs), 0);
    tick(1);
    check(!done && errCode == 2'd0, "R6 done is one cycle, code holds", int'(done), 0);
    check(!misoOe && !misoOut && !busy, "R10 output released after frame",
          int'({misoOe, misoOut, busy}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    bit seen, rs;
    int cnt;
    tick(5);
    rstN = 1'b1;
    tick(2);
    // R1: idle state
    check(!reqOut && !misoOe && !misoOut && !busy && !done && errCode == 2'd0,
          "R1 reset state", int'({reqOut, misoOe, misoOut, busy, done, errCode}), 0);

    // Sweep small and boundary payload lengths (R4, R5)
    for (int len = 0; len <= 8; len++) runFrame(16'hA55A ^ 16'(len * 257), len, 0, len, 0);
    for (int len = 60; len <= 64; len++) runFrame(16'h3C00 + 16'(len), len, 0, len + 3, 0);

    // R10: clock a byte past the payload
    runFrame(16'h1234, 5, 8, 9, 0);
    // R11: start pulse during the command phase
    runFrame(16'hBEEF, 3, 0, 4, 1);

    // R7: length above maximum rejected
    for (int len = 65; len <= 67; len++) begin
      pulseStart(16'h0F0F, len);
      check(done && errCode == 2'd1 && !reqOut, "R7 long length rejected",
            int'(errCode), 1);
      tick(1);
      check(!done && !reqOut && !busy, "R7 no request after reject", int'(reqOut), 0);
    end

    // R8: timeout in command phase
    pulseStart(16'h5555, 2);
    cnt = 0;
    while (reqOut && cnt < 100) begin cnt++; tick(1); end
    check(cnt == TO, "R8 request width before timeout", cnt, TO);
    check(done && errCode == 2'd2, "R8 timeout code", int'(errCode), 2);
    tick(1);
    check(errCode == 2'd2 && !done, "R6 code holds after timeout", int'(errCode), 2);

    // R8: timeout in payload phase
    curSeed = 1;
    pulseStart(16'h6666, 4);
    waitReq(seen);
    ackIn = 1'b1; tick(8); shiftBits(16); tick(4); ackIn = 1'b0;
    waitReq(seen);
    cnt = 0;
    while (reqOut && cnt < 100) begin cnt++; tick(1); end
    check(seen && cnt == TO, "R8 payload phase request width", cnt, TO);
    check(done && errCode == 2'd2, "R8 payload phase timeout code", int'(errCode), 2);

    // R9: short command phase
    pulseStart(16'h7777, 4);
    waitReq(seen);
    ackIn = 1'b1; tick(8); shiftBits(10); tick(4); ackIn = 1'b0;
    waitDone(seen, rs);
    check(seen && errCode == 2'd3, "R9 short command phase", int'(errCode), 3);
    cnt = 0;
    for (int i = 0; i < 30; i++) begin if (reqOut) cnt++; tick(1); end
    check(cnt == 0, "R9 no request after short phase", cnt, 0);

    // R9: short payload phase
    pulseStart(16'h8888, 4);
    waitReq(seen);
    ackIn = 1'b1; tick(8); shiftBits(16); tick(4); ackIn = 1'b0;
    waitReq(seen);
    ackIn = 1'b1; tick(8); shiftBits(31); tick(4); ackIn = 1'b0;
    waitDone(seen, rs);
    check(seen && errCode == 2'd3, "R9 short payload phase", int'(errCode), 3);

    // Recovery after errors
    runFrame(16'hC3C3, 2, 0, 7, 0);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule